// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz time base into a programmable periodic interrupt. A free-running tick counter advances once for each single-cycle 32 kHz tick enable. A 4-bit rate selector picks a power-of-two period from that count, and an event fires each time the count reaches a multiple of the period.

Each event is a one-cycle pulse. It also sets two sticky status flags: a periodic flag and a summary interrupt flag. The summary flag drives the interrupt line. Both flags stay set until a clear strobe, which is normally the read of the status register.

Because events are tied to the free-running count and not to the time of a configuration change, a new rate or a new enable takes effect at the next boundary of the new period. The whole block runs on the system clock.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset the event pulse and both flags are 0 and the tick count is 0, so the first event comes after exactly one period of ticks.
- R2: For a rate code c from 3 to 15, an event fires when the tick count, after the tick, is a multiple of 2^(c-1) ticks.
- R3: Rate code 1 behaves exactly like code 8 (period 128 ticks), and rate code 2 behaves exactly like code 9 (period 256 ticks).
- R4: Rate code 0 produces no events.
- R5: While the enable input is low, no events fire, and the tick count keeps running.
- R6: After the rate changes, the next event falls on the next multiple of the new period in the free-running count, not one full period after the change.
- R7: The event pulse lasts one cycle and appears only in the cycle after the tick that completes a period.
- R8: Each event sets the periodic flag and the summary flag in the following cycle.
- R9: A clear strobe clears both flags. If an event sets the flags in the same cycle as a clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | Single-cycle enable, one per 32.768 kHz period |
| rate_sel | input | 4 | Rate-select code |
| pie_en | input | 1 | Periodic event enable |
| flag_clr | input | 1 | Clears both status flags |
| evt_pulse | output | 1 | One-cycle periodic event |
| pf_flag | output | 1 | Sticky periodic flag |
| irqf_flag | output | 1 | Sticky summary flag; drives the interrupt line |

## Verification
The bench builds the block with its defaults: a 16-bit count and a 4-bit code. That makes every rate reachable, including the 16384-tick period of code 15.

Ticks that arrive every cycle let the longest periods complete within the run. Random tick gaps show that only ticks advance the count, not clock cycles. The bench also switches rates partway through a long period, so that realignment to the free-running count is visible.

// File: rtl/pirg_pkg.sv
// Shared helpers for the periodic rate generator.
// Assumes the rate code is 4 bits wide.
package pirg_pkg;
    // Map a rate code to its effective code: 1 becomes 8, 2 becomes 9.
    function automatic logic [4:0] eff_code(input logic [3:0] code);
        logic [4:0] r;
        case (code)
            4'd1:    r = 5'd8;
            4'd2:    r = 5'd9;
            default: r = {1'b0, code};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pirg_rate_decode.sv
// Decodes the rate code into an active flag and a low-bit mask for the
// tick count. The period is 2^(eff-1) ticks.
// Assumes CNT_W is larger than the widest shift, which is 14.
module pirg_rate_decode
    import pirg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);
    localparam int SHW = 5;

    logic [SHW-1:0] eff;
    logic [SHW-1:0] nbits;

    // Effective code, and the number of low count bits that must be zero.
    always_comb begin
        eff    = eff_code(code[3:0]);
        active = (code != '0);
        nbits  = active ? eff - 5'd1 : 5'd0;
    end

    // One mask bit per count bit: the bit is set below the period's width.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (i < int'(nbits));
    end
endmodule

// File: rtl/pirg_tick_counter.sv
// Free-running tick counter. It advances once per tick enable and is not
// affected by the enable input or the rate code.
module pirg_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_next
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_next = cnt_q + CNT_W'(1);

    // Advance the count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/pirg_event_gen.sv
// Registers a one-cycle event when a tick takes the count onto a period
// boundary while the block is enabled and the rate is active.
module pirg_event_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] mask,
    output logic             evt
);
    // Fire on a boundary; the pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= tick && enable && active && ((cnt_next & mask) == '0);
    end

    assert_evt_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !evt);
    assert_no_evt_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !evt);
    assert_no_evt_code0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !evt);
endmodule

// File: rtl/pirg_flags.sv
// Sticky periodic and summary flags. An event sets both; a clear strobe
// clears both; an event in the same cycle as a clear wins.
module pirg_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pf,
    output logic irqf
);
    // Set on an event, otherwise clear on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf   <= 1'b0;
            irqf <= 1'b0;
        end else if (evt) begin
            pf   <= 1'b1;
            irqf <= 1'b1;
        end else if (clr) begin
            pf   <= 1'b0;
            irqf <= 1'b0;
        end
    end

    assert_evt_sets_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (pf && irqf));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!pf && !irqf));
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt) |=> ($stable(pf) && $stable(irqf)));
endmodule

// File: rtl/periodic_rate_gen.sv
// Top of the periodic interrupt rate generator. It decodes the rate,
// counts ticks, generates events and holds the status flags.
// Assumes tick_32k is a single-cycle enable, synchronous to clk.
module periodic_rate_gen #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              flag_clr,
    output logic              evt_pulse,
    output logic              pf_flag,
    output logic              irqf_flag
);
    logic             active;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt_next;

    pirg_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dec (
        .code(rate_sel), .active(active), .mask(mask));

    pirg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .cnt_next(cnt_next));

    pirg_event_gen #(.CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .enable(pie_en),
        .active(active), .cnt_next(cnt_next), .mask(mask), .evt(evt_pulse));

    pirg_flags u_flg (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(flag_clr),
        .pf(pf_flag), .irqf(irqf_flag));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);
endmodule

// File: tb/test_periodic_rate_gen.sv
module test_periodic_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       evt_pulse, pf_flag, irqf_flag;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    string tag = "R1";
    bit done = 0;

    // Reference state built from the requirements
    logic [15:0] m_cnt = '0;
    logic        m_evt = 1'b0, m_pf = 1'b0, m_irqf = 1'b0;

    periodic_rate_gen i_periodic_rate_gen (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .pie_en(pie_en), .flag_clr(flag_clr), .evt_pulse(evt_pulse),
        .pf_flag(pf_flag), .irqf_flag(irqf_flag));

    always #5 clk = ~clk;

    // Period in ticks for a rate code; codes 1 and 2 map to 8 and 9.
    function automatic int unsigned period_of(input logic [3:0] c);
        int e;
        e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return 32'd1 << (e - 1);
    endfunction

    // Expected event after a tick that takes the count to cnt_after.
    function automatic logic exp_evt(input logic [3:0] c, input logic en,
                                     input logic t, input logic [15:0] cnt_after);
        if (!t || !en || c == 4'd0) return 1'b0;
        return ((32'(cnt_after) % period_of(c)) == 0);
    endfunction

    // Reference model, advanced at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_evt <= 1'b0; m_pf <= 1'b0; m_irqf <= 1'b0;
        end else begin
            if (tick_32k) m_cnt <= m_cnt + 16'd1;
            m_evt <= exp_evt(rate_sel, pie_en, tick_32k, m_cnt + 16'd1);
            if (m_evt) begin
                m_pf <= 1'b1; m_irqf <= 1'b1;
            end else if (flag_clr) begin
                m_pf <= 1'b0; m_irqf <= 1'b0;
            end
        end
    end

    task automatic check(input string t, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", t, what, act, exp, cycles);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check(tag, "evt_pulse", evt_pulse, m_evt);
            check("R8 R9", "pf_flag", pf_flag, m_pf);
            check("R8 R9", "irqf_flag", irqf_flag, m_irqf);
        end
    end

    task automatic run(input int n, input int tick_div, input int clr_div);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_32k = (tick_div <= 1) ? 1'b1 : (($urandom % tick_div) == 0);
            flag_clr = (clr_div > 0) ? (($urandom % clr_div) == 0) : 1'b0;
        end
    endtask

    // Watchdog
    initial begin
        #1900000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "evt_pulse reset", evt_pulse, 1'b0);
        check("R1", "pf_flag reset", pf_flag, 1'b0);
        check("R1", "irqf_flag reset", irqf_flag, 1'b0);
        rst_n = 1'b1; rate_sel = 4'd3; pie_en = 1'b1;
        tag = "R1";  run(12, 1, 0);
        tag = "R2";  run(200, 1, 6);
        tag = "R3";  rate_sel = 4'd1; run(700, 1, 20);
        tag = "R3";  rate_sel = 4'd2; run(1100, 1, 20);
        tag = "R4";  rate_sel = 4'd0; run(600, 1, 0);
        tag = "R5";  rate_sel = 4'd3; pie_en = 1'b0; run(300, 1, 0);
        tag = "R5";  pie_en = 1'b1; run(100, 1, 4);
        // R6: switch from a long period to a short one mid-period
        tag = "R6";  rate_sel = 4'd15; run(20000, 1, 50);
        tag = "R6";  rate_sel = 4'd5; run(100, 1, 0);
        tag = "R6";  rate_sel = 4'd12; run(3000, 1, 0);
        // Random segments: codes, enables, tick gaps, clears
        for (int s = 0; s < 40; s++) begin
            tag = "R2 R7";
            rate_sel = 4'($urandom % 16);
            pie_en = (($urandom % 5) != 0);
            run(1500, int'($urandom % 4) + 1, int'($urandom % 10));
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule